// File: doc/BRIEF.md
# Per-CPU masked device interrupt router

This block collects up to 64 level-sensitive device interrupt lines into a raw request vector and hands that vector to four processors. Each processor owns a 64-bit enable mask. The AND of its mask with the raw vector is its masked request word. The processor's interrupt output is high whenever that word has any bit set.

One request position, bit 55, is not taken from the device lines. It follows the output of the cascaded legacy interrupt controller instead.

Software reaches the block through a 32-bit register port. A 64-bit register is moved as two 32-bit halves through one shared holding latch:

- **Writing.** Software first writes the low half at the register offset. It then writes the high half at offset+4, and that second access commits the full 64-bit value.
- **Reading.** Software first reads the low half. That read also captures the high half, which the next access at offset+4 returns.

Top module: `irq_router`

## Requirements
- R1: Raw request bit n (n other than 55) takes the level of input line n at each rising clock edge. The raw vector reads back at offset 0x300 (low half) and 0x304 (high half).
- R2: Raw request bit 55 takes the level of the cascade input. Input line 55 has no effect on it.
- R3: The masked request word of CPU i equals mask_i AND raw. It reads at offsets 0x280, 0x2C0, 0x680 and 0x6C0 for CPUs 0, 1, 2 and 3.
- R4: Output cpuIrq[i] is high exactly when CPU i's masked word is nonzero. A line change shows on the outputs after the first rising edge that samples it.
- R5: The masks of CPUs 0 to 3 are read and written at offsets 0x200, 0x240, 0x600 and 0x640. The low half is at the offset and the high half at offset+4.
- R6: Committing a mask changes that CPU's output right after the committing clock edge, judged against the current raw vector.
- R7: A write to an offset with address bit 2 clear only stores the write data in the holding latch and changes no register. A write with address bit 2 set commits {write data, latch} to the register at the address with bit 2 cleared.
- R8: A read with address bit 2 clear returns bits 31:0 of the register and captures bits 63:32 into the latch. A read with address bit 2 set returns the latch.
- R9: Writes to the masked-request offsets and the raw offset are ignored.
- R10: A read of an undecoded offset with bit 2 clear returns 0xFFFFFFFF and leaves the latch unchanged.
- R11: After reset all masks, the raw vector and the latch are zero, and every cpuIrq output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | 64 | Device interrupt levels, one per raw request bit |
| cascadeIrq | input | 1 | Legacy controller output, drives raw bit 55 |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 12 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle regRdEn is high |
| cpuIrq | output | 4 | Interrupt output of each CPU |

## Verification
A table of six steps is run. Each step programs one CPU's mask and then applies a new line pattern:

- **Single low bit.** Shows whether the low half of the 64-bit path works.
- **High bit only on line 55.** A correct design ignores line 55, so this tells a cascade-driven bit 55 from one wrongly taken from the device line.
- **High-word-only mask.** Exposes a swap of the two halves or a dropped latch.
- **All-ones lines with a cleared mask.** Separates a blocked CPU from the others, which stay enabled.

Directed sequences then cover the remaining corners:

- **Mask-write timing.** A low-half mask write must leave the output alone, and the following high-half write must move it at once.
- **Read-only offsets.** Writes to them must not disturb state.
- **Undecoded read.** Must return all ones without overwriting a captured high half.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int WORD_W      = 32;
  localparam int REQ_W       = 2 * WORD_W;
  localparam int NUM_CPU     = 4;
  localparam int CPU_IDX_W   = $clog2(NUM_CPU);
  localparam int REG_ADDR_W  = 12;
  localparam int CASCADE_BIT = 55;
  localparam logic [REG_ADDR_W-1:0] RAW_OFF = 12'h300;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LATCH,
    RD_MASK,
    RD_MASKED,
    RD_RAW
  } rdSel_e;

  typedef struct packed {
    logic                 latchWrite;
    logic                 latchRead;
    logic [NUM_CPU-1:0]   maskWr;
    rdSel_e               rdSel;
    logic [CPU_IDX_W-1:0] rdCpu;
  } ctrlStrobes_t;

  // CPUs 0/1 sit in the lower group, CPUs 2/3 in the upper group.
  function automatic logic [REG_ADDR_W-1:0] maskOff(int cpu);
    logic [REG_ADDR_W-1:0] base;
    base = (cpu >= 2) ? 12'h600 : 12'h200;
    if (cpu % 2 == 1) base = base + 12'h040;
    return base;
  endfunction

  function automatic logic [REG_ADDR_W-1:0] maskedOff(int cpu);
    return maskOff(cpu) + 12'h080;
  endfunction
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output ctrlStrobes_t          strb
);
  logic [REG_ADDR_W-1:0] alignedAddr;
  logic                  rdHit;

  assign alignedAddr = {regAddr[REG_ADDR_W-1:3], 1'b0, regAddr[1:0]};

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    rdHit      = 1'b0;
    // write side: low half only fills the latch
    if (regWrEn) begin
      if (!regAddr[2]) begin
        strb.latchWrite = 1'b1;
      end else begin
        for (int i = 0; i < NUM_CPU; i++) begin
          if (alignedAddr == maskOff(i)) strb.maskWr[i] = 1'b1;
        end
      end
    end
    // read side select
    if (regAddr[2]) begin
      strb.rdSel = RD_LATCH;
    end else begin
      if (alignedAddr == RAW_OFF) begin
        strb.rdSel = RD_RAW;
        rdHit      = 1'b1;
      end
      for (int i = 0; i < NUM_CPU; i++) begin
        if (alignedAddr == maskOff(i)) begin
          strb.rdSel = RD_MASK;
          strb.rdCpu = CPU_IDX_W'(i);
          rdHit      = 1'b1;
        end
        if (alignedAddr == maskedOff(i)) begin
          strb.rdSel = RD_MASKED;
          strb.rdCpu = CPU_IDX_W'(i);
          rdHit      = 1'b1;
        end
      end
    end
    strb.latchRead = regRdEn && !regWrEn && !regAddr[2] && rdHit;
  end

  p_low_write_no_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr[2]) |-> (strb.maskWr == '0));

  p_single_mask_strobe_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.maskWr));

  p_undecoded_no_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == RD_NONE) |-> !strb.latchRead);
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [WORD_W-1:0]  regWrData,
  input  logic [REQ_W-1:0]   irqLines,
  input  logic               cascadeIrq,
  output logic [WORD_W-1:0]  regRdData,
  output logic [NUM_CPU-1:0] cpuIrq
);
  logic [REQ_W-1:0]  lineVec;
  logic [REQ_W-1:0]  rawReq;
  logic [REQ_W-1:0]  mask      [NUM_CPU];
  logic [REQ_W-1:0]  maskedReq [NUM_CPU];
  logic [WORD_W-1:0] halfLatch;
  logic [REQ_W-1:0]  selWord;

  always_comb begin
    lineVec              = irqLines;
    lineVec[CASCADE_BIT] = cascadeIrq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawReq <= '0;
    else       rawReq <= lineVec;
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : gCpu
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               mask[g] <= '0;
      else if (strb.maskWr[g]) mask[g] <= {regWrData, halfLatch};
    end
    assign maskedReq[g] = mask[g] & rawReq;
    assign cpuIrq[g]    = |maskedReq[g];

    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      !strb.maskWr[g] |=> $stable(mask[g]));

    p_irq_track_r4: assert property (@(posedge clk) disable iff (!rstN)
      ($stable(rawReq) && $stable(mask[g])) |-> $stable(cpuIrq[g]));
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_MASK:   selWord = mask[strb.rdCpu];
      RD_MASKED: selWord = maskedReq[strb.rdCpu];
      RD_RAW:    selWord = rawReq;
      default:   selWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                halfLatch <= '0;
    else if (strb.latchWrite) halfLatch <= regWrData;
    else if (strb.latchRead)  halfLatch <= selWord[REQ_W-1:WORD_W];
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_NONE:  regRdData = '1;
      RD_LATCH: regRdData = halfLatch;
      default:  regRdData = selWord[WORD_W-1:0];
    endcase
  end

  p_cascade_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (rawReq[CASCADE_BIT] == $past(cascadeIrq)));

  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.latchWrite && !strb.latchRead) |=> $stable(halfLatch));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REQ_W-1:0]      irqLines,
  input  logic                  cascadeIrq,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0]     regWrData,
  output logic [WORD_W-1:0]     regRdData,
  output logic [NUM_CPU-1:0]    cpuIrq
);
  ctrlStrobes_t strb;

  irq_router_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  irq_router_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regWrData  (regWrData),
    .irqLines   (irqLines),
    .cascadeIrq (cascadeIrq),
    .regRdData  (regRdData),
    .cpuIrq     (cpuIrq)
  );
endmodule

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] irqLines = '0;
  logic        cascadeIrq = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [3:0]  cpuIrq;

  int checks = 0;
  int failures = 0;

  irq_router dut (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  cpu;
    logic [63:0] maskVal;
    logic [63:0] lines;
    logic        casc;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b0},
    '{2'd1, 64'h0080_0000_0000_0000, 64'h0080_0000_0000_0000, 1'b0},
    '{2'd1, 64'h0080_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1},
    '{2'd2, 64'hFFFF_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0},
    '{2'd3, 64'h0000_0000_FFFF_FFFF, 64'hA5A5_0000_0000_0001, 1'b0},
    '{2'd0, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1}
  };

  logic [63:0] shMask [4];
  logic [63:0] expRaw;

  function automatic logic [11:0] maskAddr(int c);
    logic [11:0] a;
    a = (c >= 2) ? 12'h600 : 12'h200;
    if (c % 2 == 1) a = a + 12'h040;
    return a;
  endfunction

  function automatic logic [3:0] expIrq();
    logic [3:0] e;
    for (int c = 0; c < 4; c++) e[c] = |(shMask[c] & expRaw);
    return e;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic rd64(logic [11:0] a, output logic [63:0] d);
    logic [31:0] lo, hi;
    rd(a, lo);
    rd(a | 12'h004, hi);
    d = {hi, lo};
  endtask

  task automatic wr64(logic [11:0] a, logic [63:0] d);
    wr(a, d[31:0]);
    wr(a | 12'h004, d[63:32]);
  endtask

  task automatic setLines(logic [63:0] l, logic c);
    @(negedge clk);
    irqLines = l; cascadeIrq = c;
    expRaw = l; expRaw[55] = c;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [31:0] w;
    for (int c = 0; c < 4; c++) shMask[c] = '0;
    expRaw = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    chk("R11 cpuIrq after reset", {60'd0, cpuIrq}, 64'd0);
    rd(12'h204, w);
    chk("R11 latch after reset", {32'd0, w}, 64'd0);
    for (int c = 0; c < 4; c++) begin
      rd64(maskAddr(c), v);
      chk("R11 mask after reset", v, 64'd0);
    end

    // table walk: R1 R2 R3 R4 R5 R8
    for (int k = 0; k < 6; k++) begin
      wr64(maskAddr(VEC[k].cpu), VEC[k].maskVal);
      shMask[VEC[k].cpu] = VEC[k].maskVal;
      setLines(VEC[k].lines, VEC[k].casc);
      rd64(12'h300, v);
      chk("R1 R2 raw vector", v, expRaw);
      rd64(maskAddr(VEC[k].cpu), v);
      chk("R5 R8 mask readback", v, VEC[k].maskVal);
      rd64(maskAddr(VEC[k].cpu) + 12'h080, v);
      chk("R3 masked word", v, VEC[k].maskVal & expRaw);
      chk("R4 cpuIrq vector", {60'd0, cpuIrq}, {60'd0, expIrq()});
    end

    // R2 explicit: line 55 high, cascade low -> bit 55 clear
    setLines(64'h0080_0000_0000_0000, 1'b0);
    rd64(12'h300, v);
    chk("R2 line55 ignored", {63'd0, v[55]}, 64'd0);

    // R6 / R7 mask write timing on CPU 2
    wr64(maskAddr(2), 64'd0); shMask[2] = '0;
    setLines(64'h0000_0000_0000_0008, 1'b0);
    chk("R6 cpu2 off before", {63'd0, cpuIrq[2]}, 64'd0);
    wr(maskAddr(2), 32'h0000_0008);
    chk("R7 low write leaves output", {63'd0, cpuIrq[2]}, 64'd0);
    rd(maskAddr(2) | 12'h004, w);
    chk("R7 low write fills latch", {32'd0, w}, 64'h0000_0000_0000_0008);
    rd64(maskAddr(2), v);
    chk("R7 low write no commit", v, 64'd0);
    wr(maskAddr(2), 32'h0000_0008);
    wr(maskAddr(2) | 12'h004, 32'h0);
    shMask[2] = 64'h8;
    chk("R6 output right after commit", {63'd0, cpuIrq[2]}, 64'd1);

    // R9 read-only offsets ignore writes
    wr64(12'h300, 64'hDEAD_BEEF_0000_0000);
    rd64(12'h300, v);
    chk("R9 raw not writable", v, expRaw);
    wr64(12'h680, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(maskAddr(2), v);
    chk("R9 masked write leaves mask", v, 64'h8);
    chk("R9 outputs unchanged", {60'd0, cpuIrq}, {60'd0, expIrq()});

    // R10 undecoded read
    wr64(maskAddr(3), 64'h1234_5678_0000_0000); shMask[3] = 64'h1234_5678_0000_0000;
    rd(maskAddr(3), w);
    rd(12'h100, w);
    chk("R10 undecoded returns ones", {32'd0, w}, 64'h0000_0000_FFFF_FFFF);
    rd(12'h104, w);
    chk("R10 R8 latch kept", {32'd0, w}, 64'h0000_0000_1234_5678);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule